// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the sixteen 32-bit general registers of a processor core together with its current status word and one saved status word per exception mode. Registers 8 through 14 are not a single set of flops: depending on the current processor mode, some or all of them are backed by a private copy. The fast-interrupt mode owns private copies of all seven. The interrupt, supervisor, abort and undefined modes each own private copies of only registers 13 and 14. User and system modes share one common set. The live registers always show the view of the current mode, so both read ports stay purely combinational.

A status write that changes the mode field moves the affected live registers into storage for the old mode and fills them from storage for the new mode, all on the clock edge that accepts the write. Only registers whose owning bank differs between the two modes are moved. For example, registers 8 to 12 stay in place between the supervisor and interrupt modes, but they are exchanged when entering or leaving fast-interrupt mode. Reads of register 15 return the stored program counter plus a pipeline offset. Status writes go through a byte-lane mask. A write that would put an unknown code into the mode field is refused and reported with a one-cycle error pulse.

Top module: `banked_regfile`

## Requirements
- R1: After reset the current status reads 0x000000D3 (supervisor code 10011 with I at bit 7 and F at bit 6 set), the saved status reads 0, `privileged` is 1, `mode_err` is 0, and every general register reads 0 except index 15, which reads 8.
- R2: A general-register write takes effect on the next clock edge and is visible on both read ports, which are combinational.
- R3: Reading index 15 returns the stored value plus PC_AHEAD (default 8). Every other index returns the stored value.
- R4: A status write merges under `psr_mask`: mask bit 3 enables bits 31:24, bit 2 enables 23:16, bit 1 enables 15:8 and bit 0 enables 7:0. Disabled lanes keep their old value.
- R5: A status write that leaves the mode field at its current code updates the word and leaves every general register unchanged.
- R6: Fast-interrupt mode (code 10001) sees private registers 8 to 14. Leaving it restores the other modes' values of those registers.
- R7: Interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) modes each see private registers 13 and 14, and share registers 8 to 12 with user mode.
- R8: User (10000) and system (11111) modes share one set of registers 8 to 14.
- R9: With `psr_sel_saved`=1, a write goes to the saved status of the current mode, and `saved_psr` shows that mode's saved status. In user and system modes such writes are ignored and `saved_psr` reads 0.
- R10: A current-status write whose merged mode field is not one of the seven codes is rejected: the status word and registers stay unchanged, and `mode_err` is 1 for exactly the cycle after the write.
- R11: `privileged` is 0 exactly when the current mode code is 10000 (user).
- R12: A register write in the same cycle as a mode-changing status write lands in the old mode's view of that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General-register write enable |
| wr_idx | input | 4 | General-register write index |
| wr_data | input | 32 | General-register write data |
| psr_wr_en | input | 1 | Status write enable |
| psr_sel_saved | input | 1 | 0 = current status, 1 = saved status of current mode |
| psr_mask | input | 4 | Byte-lane enables for the status write |
| psr_wr_data | input | 32 | Status write data |
| cur_psr | output | 32 | Current status word |
| saved_psr | output | 32 | Saved status of current mode, 0 in user/system |
| privileged | output | 1 | High when the mode is not user |
| mode_err | output | 1 | One-cycle pulse after a rejected mode write |

## Verification
A wrong bank owner or a missed swap does not show up at the mode change. It shows up on the first read of register 8 to 14 after the change, and it can stay hidden until the mode is left and entered again. For this reason the tests go into a mode, write its private registers, leave, and come back. This exposes values that were saved to the wrong bank or never restored. A wrong saved-status index shows up on `saved_psr` in the same cycle as the mode change. A lane-mask error shows up on `cur_psr` one edge after the write.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  localparam int NUM_GPR   = 16;
  localparam int BANK_LO   = 8;
  localparam int BANK_HI   = 14;
  localparam int PRIV_LO   = 13;
  localparam int WIDE_CNT  = BANK_HI - BANK_LO + 1;
  localparam int NARROW_CNT = BANK_HI - PRIV_LO + 1;
  localparam int EXC_MODES = 4;
  localparam int SAVED_CNT = 5;
  localparam int T_BIT     = 5;
  localparam int F_BIT     = 6;
  localparam int I_BIT     = 7;

  typedef enum logic [4:0] {
    MC_USR = 5'b10000,
    MC_FIQ = 5'b10001,
    MC_IRQ = 5'b10010,
    MC_SVC = 5'b10011,
    MC_ABT = 5'b10111,
    MC_UND = 5'b11011,
    MC_SYS = 5'b11111
  } mode_code_e;

  typedef enum logic [2:0] {
    IM_USR = 3'd0,
    IM_FIQ = 3'd1,
    IM_IRQ = 3'd2,
    IM_SVC = 3'd3,
    IM_ABT = 3'd4,
    IM_UND = 3'd5,
    IM_SYS = 3'd6,
    IM_BAD = 3'd7
  } imode_e;

  localparam logic [2:0] OWN_USR  = 3'd0;
  localparam logic [2:0] OWN_FIQ  = 3'd1;
  localparam logic [2:0] OWN_NONE = 3'd7;

  localparam logic [31:0] PSR_RESET =
    (32'd1 << I_BIT) | (32'd1 << F_BIT) | {27'd0, MC_SVC};

  function automatic imode_e to_imode(input logic [4:0] code);
    case (code)
      MC_USR:  return IM_USR;
      MC_FIQ:  return IM_FIQ;
      MC_IRQ:  return IM_IRQ;
      MC_SVC:  return IM_SVC;
      MC_ABT:  return IM_ABT;
      MC_UND:  return IM_UND;
      MC_SYS:  return IM_SYS;
      default: return IM_BAD;
    endcase
  endfunction

  function automatic logic [31:0] lane_mask(input logic [3:0] m);
    return {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
  endfunction

  function automatic logic [31:0] lane_merge(input logic [31:0] old_w,
                                             input logic [31:0] new_w,
                                             input logic [3:0]  m);
    logic [31:0] lm;
    lm = lane_mask(m);
    return (old_w & ~lm) | (new_w & lm);
  endfunction

  function automatic logic has_saved(input imode_e m);
    return (m == IM_FIQ) || (m == IM_IRQ) || (m == IM_SVC) ||
           (m == IM_ABT) || (m == IM_UND);
  endfunction

  // Which storage backs register r while mode m is current.
  function automatic logic [2:0] bank_owner(input imode_e m, input int r);
    if (r < BANK_LO || r > BANK_HI) return OWN_NONE;
    if (m == IM_FIQ) return OWN_FIQ;
    if (r >= PRIV_LO && (m == IM_IRQ || m == IM_SVC || m == IM_ABT || m == IM_UND))
      return 3'(m);
    return OWN_USR;
  endfunction

  function automatic logic [31:0] pc_view(input logic [3:0] idx,
                                          input logic [31:0] stored,
                                          input logic [31:0] ahead);
    return (idx == 4'd15) ? stored + ahead : stored;
  endfunction

endpackage

// File: rtl/rb_slot.sv
module rb_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/rb_status.sv
module rb_status
  import regbank_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            psr_wr_en,
  input  logic            psr_sel_saved,
  input  logic [3:0]      psr_mask,
  input  logic [XLEN-1:0] psr_wr_data,
  output logic [XLEN-1:0] cur_psr,
  output logic [XLEN-1:0] saved_psr,
  output imode_e          cur_mode,
  output imode_e          nxt_mode,
  output logic            swap_evt,
  output logic            mode_err
);
  logic [XLEN-1:0] cpsr_q;
  logic [XLEN-1:0] cand;
  imode_e          cand_mode;
  logic            cur_wr, bad_wr, accept;
  logic [XLEN-1:0] spsr_q [SAVED_CNT];

  assign cur_mode  = to_imode(cpsr_q[4:0]);
  assign cand      = lane_merge(cpsr_q, psr_wr_data, psr_mask);
  assign cand_mode = to_imode(cand[4:0]);
  assign cur_wr    = psr_wr_en && !psr_sel_saved;
  assign bad_wr    = cur_wr && (cand_mode == IM_BAD);
  assign accept    = cur_wr && !bad_wr;
  assign swap_evt  = accept && (cand_mode != cur_mode);
  assign nxt_mode  = swap_evt ? cand_mode : cur_mode;
  assign cur_psr   = cpsr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpsr_q   <= PSR_RESET;
      mode_err <= 1'b0;
    end else begin
      if (accept) cpsr_q <= cand;
      mode_err <= bad_wr;
    end
  end

  for (genvar k = 0; k < SAVED_CNT; k++) begin : g_saved
    logic sel;
    assign sel = psr_wr_en && psr_sel_saved && (cur_mode == imode_e'(3'(k + 1)));
    rb_slot #(.W(XLEN)) u_slot (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (sel),
      .d    (lane_merge(spsr_q[k], psr_wr_data, psr_mask)),
      .q    (spsr_q[k])
    );
  end

  always_comb begin
    saved_psr = '0;
    for (int k = 0; k < SAVED_CNT; k++)
      if (has_saved(cur_mode) && cur_mode == imode_e'(3'(k + 1)))
        saved_psr = spsr_q[k];
  end
endmodule

// File: rtl/rb_gpr.sv
module rb_gpr
  import regbank_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter logic [31:0] PC_AHEAD = 32'd8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      rd_a_idx,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [3:0]      rd_b_idx,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            wr_en,
  input  logic [3:0]      wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  imode_e          cur_mode,
  input  imode_e          nxt_mode,
  input  logic            swap_evt
);
  logic [XLEN-1:0] live_q [NUM_GPR];
  logic [XLEN-1:0] live_d [NUM_GPR];
  logic [XLEN-1:0] wv     [NUM_GPR];
  logic [XLEN-1:0] usr_q  [WIDE_CNT];
  logic [XLEN-1:0] fiq_q  [WIDE_CNT];
  logic [XLEN-1:0] exc_q  [EXC_MODES][NARROW_CNT];

  // Live view after this cycle's register write, before any bank exchange.
  always_comb begin
    for (int r = 0; r < NUM_GPR; r++) wv[r] = live_q[r];
    if (wr_en) wv[wr_idx] = wr_data;
  end

  for (genvar r = 0; r < NUM_GPR; r++) begin : g_reg
    if (r >= BANK_LO && r <= BANK_HI) begin : g_bank
      logic [2:0]      ob, nb;
      logic            moved;
      logic [XLEN-1:0] ld;
      assign ob    = bank_owner(cur_mode, r);
      assign nb    = bank_owner(nxt_mode, r);
      assign moved = swap_evt && (ob != nb);
      if (r >= PRIV_LO) begin : g_hi
        logic [1:0] sidx;
        assign sidx = nb[1:0] - 2'd2;
        assign ld = (nb == OWN_USR) ? usr_q[r-BANK_LO] :
                    (nb == OWN_FIQ) ? fiq_q[r-BANK_LO] :
                                      exc_q[sidx][r-PRIV_LO];
      end else begin : g_lo
        assign ld = (nb == OWN_FIQ) ? fiq_q[r-BANK_LO] : usr_q[r-BANK_LO];
      end
      assign live_d[r] = moved ? ld : wv[r];
    end else begin : g_flat
      assign live_d[r] = wv[r];
    end
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < NUM_GPR; r++) begin
      if (!rst_n) live_q[r] <= '0;
      else        live_q[r] <= live_d[r];
    end
  end

  for (genvar j = 0; j < WIDE_CNT; j++) begin : g_wide
    logic usr_en, fiq_en;
    assign usr_en = swap_evt && bank_owner(cur_mode, j + BANK_LO) == OWN_USR &&
                    bank_owner(nxt_mode, j + BANK_LO) != OWN_USR;
    assign fiq_en = swap_evt && bank_owner(cur_mode, j + BANK_LO) == OWN_FIQ &&
                    bank_owner(nxt_mode, j + BANK_LO) != OWN_FIQ;
    rb_slot #(.W(XLEN)) u_usr (
      .clk(clk), .rst_n(rst_n), .en(usr_en), .d(wv[j+BANK_LO]), .q(usr_q[j]));
    rb_slot #(.W(XLEN)) u_fiq (
      .clk(clk), .rst_n(rst_n), .en(fiq_en), .d(wv[j+BANK_LO]), .q(fiq_q[j]));
  end

  for (genvar m = 0; m < EXC_MODES; m++) begin : g_exc
    for (genvar e = 0; e < NARROW_CNT; e++) begin : g_ent
      logic en;
      assign en = swap_evt &&
                  bank_owner(cur_mode, e + PRIV_LO) == 3'(m + 2) &&
                  bank_owner(nxt_mode, e + PRIV_LO) != 3'(m + 2);
      rb_slot #(.W(XLEN)) u_ent (
        .clk(clk), .rst_n(rst_n), .en(en), .d(wv[e+PRIV_LO]), .q(exc_q[m][e]));
    end
  end

  assign rd_a_data = pc_view(rd_a_idx, live_q[rd_a_idx], PC_AHEAD);
  assign rd_b_data = pc_view(rd_b_idx, live_q[rd_b_idx], PC_AHEAD);
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import regbank_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter logic [31:0] PC_AHEAD = 32'd8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      rd_a_idx,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [3:0]      rd_b_idx,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            wr_en,
  input  logic [3:0]      wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            psr_wr_en,
  input  logic            psr_sel_saved,
  input  logic [3:0]      psr_mask,
  input  logic [XLEN-1:0] psr_wr_data,
  output logic [XLEN-1:0] cur_psr,
  output logic [XLEN-1:0] saved_psr,
  output logic            privileged,
  output logic            mode_err
);
  imode_e cur_mode, nxt_mode;
  logic   swap_evt;

  rb_status #(.XLEN(XLEN)) u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .psr_wr_en    (psr_wr_en),
    .psr_sel_saved(psr_sel_saved),
    .psr_mask     (psr_mask),
    .psr_wr_data  (psr_wr_data),
    .cur_psr      (cur_psr),
    .saved_psr    (saved_psr),
    .cur_mode     (cur_mode),
    .nxt_mode     (nxt_mode),
    .swap_evt     (swap_evt),
    .mode_err     (mode_err)
  );

  rb_gpr #(.XLEN(XLEN), .PC_AHEAD(PC_AHEAD)) u_gpr (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_idx (rd_a_idx),
    .rd_a_data(rd_a_data),
    .rd_b_idx (rd_b_idx),
    .rd_b_data(rd_b_data),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .cur_mode (cur_mode),
    .nxt_mode (nxt_mode),
    .swap_evt (swap_evt)
  );

  assign privileged = (cur_mode != IM_USR);
endmodule

// File: rtl/rb_checker.sv
module rb_checker
  import regbank_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        psr_wr_en,
  input logic        psr_sel_saved,
  input logic [3:0]  psr_mask,
  input logic [31:0] psr_wr_data,
  input logic [31:0] cur_psr,
  input logic [31:0] saved_psr,
  input logic        privileged,
  input logic        mode_err,
  input logic        swap_evt
);
  logic [31:0] merged;
  logic        bad_req;
  logic        unbanked;

  assign merged   = lane_merge(cur_psr, psr_wr_data, psr_mask);
  assign bad_req  = psr_wr_en && !psr_sel_saved && (to_imode(merged[4:0]) == IM_BAD);
  assign unbanked = (cur_psr[4:0] == MC_USR) || (cur_psr[4:0] == MC_SYS);

  // R10: refused mode write keeps the status word and raises the pulse
  a_r10_reject: assert property (@(posedge clk) disable iff (!rst_n)
    bad_req |=> (cur_psr == $past(cur_psr)) && mode_err);

  // R10: the pulse only follows a refused write
  a_r10_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> $past(bad_req));

  // R5: a bank exchange is always followed by a different mode code
  a_r5_swap_changes_mode: assert property (@(posedge clk) disable iff (!rst_n)
    swap_evt |=> cur_psr[4:0] != $past(cur_psr[4:0]));

  // R9: no saved status visible in user or system mode
  a_r9_unbanked_zero: assert property (@(posedge clk) disable iff (!rst_n)
    unbanked |-> saved_psr == 32'd0);

  // R11: privilege follows the mode code
  a_r11_priv: assert property (@(posedge clk) disable iff (!rst_n)
    privileged == (cur_psr[4:0] != MC_USR));

  // R4: a current-status write with no lanes enabled leaves the word alone
  a_r4_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_wr_en && !psr_sel_saved && psr_mask == 4'd0) |=> $stable(cur_psr));
endmodule

bind banked_regfile rb_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .psr_wr_en    (psr_wr_en),
  .psr_sel_saved(psr_sel_saved),
  .psr_mask     (psr_mask),
  .psr_wr_data  (psr_wr_data),
  .cur_psr      (cur_psr),
  .saved_psr    (saved_psr),
  .privileged   (privileged),
  .mode_err     (mode_err),
  .swap_evt     (swap_evt)
);

// File: tb/banked_regfile_tb.sv
`timescale 1ns/100ps
module banked_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx, psr_mask;
  logic [31:0] rd_a_data, rd_b_data, wr_data, psr_wr_data, cur_psr, saved_psr;
  logic        wr_en, psr_wr_en, psr_sel_saved, privileged, mode_err;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  banked_regfile u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .psr_wr_en(psr_wr_en), .psr_sel_saved(psr_sel_saved),
    .psr_mask(psr_mask), .psr_wr_data(psr_wr_data),
    .cur_psr(cur_psr), .saved_psr(saved_psr),
    .privileged(privileged), .mode_err(mode_err)
  );

  // {index, data}; expected read = data, plus 8 for index 15
  localparam logic [35:0] VEC [8] = '{
    {4'd0,  32'h1111_1111}, {4'd3,  32'h3333_0003}, {4'd7,  32'hCAFE_0007},
    {4'd8,  32'h0000_00A8}, {4'd12, 32'h0000_00AC}, {4'd13, 32'h0000_00AD},
    {4'd14, 32'h0000_00AE}, {4'd15, 32'h0000_0100}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    wr_en = 1'b0; psr_wr_en = 1'b0; psr_sel_saved = 1'b0;
  endtask

  task automatic gpr_wr(input logic [3:0] i, input logic [31:0] d);
    wr_en = 1'b1; wr_idx = i; wr_data = d; tick();
  endtask

  task automatic psr_wr(input logic sel, input logic [3:0] m, input logic [31:0] d);
    psr_wr_en = 1'b1; psr_sel_saved = sel; psr_mask = m; psr_wr_data = d; tick();
  endtask

  task automatic rd(input string tag, input logic [3:0] i, input logic [31:0] exp);
    rd_a_idx = i; rd_b_idx = i; #0.5;
    chk({tag, " portA"}, rd_a_data, exp);
    chk({tag, " portB"}, rd_b_data, exp);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; psr_wr_en = 0; psr_sel_saved = 0;
    wr_idx = 0; wr_data = 0; psr_mask = 0; psr_wr_data = 0;
    rd_a_idx = 0; rd_b_idx = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk("R1 cur_psr", cur_psr, 32'h0000_00D3);
    chk("R1 saved_psr", saved_psr, 32'h0);
    chk("R1 privileged", {31'd0, privileged}, 32'd1);
    chk("R1 mode_err", {31'd0, mode_err}, 32'd0);
    rd("R1 r9", 4'd9, 32'h0);
    rd("R1 R3 r15", 4'd15, 32'h8);

    // R2 R3 vector walk
    for (int k = 0; k < 8; k++) begin
      gpr_wr(VEC[k][35:32], VEC[k][31:0]);
      rd("R2 R3 vec", VEC[k][35:32],
         VEC[k][31:0] + ((VEC[k][35:32] == 4'd15) ? 32'd8 : 32'd0));
    end

    // R4 lane masks
    psr_wr(1'b0, 4'b1000, 32'hF000_0000);
    chk("R4 top lane", cur_psr, 32'hF000_00D3);
    psr_wr(1'b0, 4'b0110, 32'h000F_FF00);
    chk("R4 mid lanes", cur_psr, 32'hF00F_FFD3);
    psr_wr(1'b0, 4'b0000, 32'h1234_5678);
    chk("R4 no lanes", cur_psr, 32'hF00F_FFD3);
    // R5 same-mode full write
    psr_wr(1'b0, 4'b1111, 32'h0000_00D3);
    chk("R5 psr", cur_psr, 32'h0000_00D3);
    rd("R5 r8", 4'd8, 32'hA8);
    rd("R5 r13", 4'd13, 32'hAD);

    // R6 fast-interrupt bank
    psr_wr(1'b0, 4'b0001, 32'h0000_00D1);
    rd("R6 r8 fresh", 4'd8, 32'h0);
    rd("R6 r14 fresh", 4'd14, 32'h0);
    rd("R6 r0 shared", 4'd0, 32'h1111_1111);
    gpr_wr(4'd8, 32'hF8); gpr_wr(4'd13, 32'hFD);
    psr_wr(1'b0, 4'b0001, 32'h0000_00D3);
    rd("R6 r8 back", 4'd8, 32'hA8);
    rd("R6 r13 back", 4'd13, 32'hAD);
    psr_wr(1'b0, 4'b0001, 32'h0000_00D1);
    rd("R6 r8 kept", 4'd8, 32'hF8);
    psr_wr(1'b0, 4'b0001, 32'h0000_00D3);

    // R7 interrupt mode: r8-12 shared, r13/14 private
    psr_wr(1'b0, 4'b0001, 32'h0000_00D2);
    rd("R7 r8 shared", 4'd8, 32'hA8);
    rd("R7 r12 shared", 4'd12, 32'hAC);
    rd("R7 r13 private", 4'd13, 32'h0);
    gpr_wr(4'd13, 32'h1D);
    psr_wr(1'b0, 4'b0001, 32'h0000_00D3);
    rd("R7 r13 svc", 4'd13, 32'hAD);

    // R8 R11 user and system share
    psr_wr(1'b0, 4'b0001, 32'h0000_0010);
    chk("R11 user unpriv", {31'd0, privileged}, 32'd0);
    rd("R8 r13 user", 4'd13, 32'h0);
    gpr_wr(4'd13, 32'h55);
    psr_wr(1'b0, 4'b0001, 32'h0000_001F);
    chk("R11 system priv", {31'd0, privileged}, 32'd1);
    rd("R8 r13 system", 4'd13, 32'h55);

    // R9 saved status
    psr_wr(1'b1, 4'b1111, 32'h0000_ABCD);
    chk("R9 system ignored", saved_psr, 32'h0);
    psr_wr(1'b0, 4'b0001, 32'h0000_00D3);
    chk("R9 svc untouched", saved_psr, 32'h0);
    psr_wr(1'b1, 4'b1111, 32'h6000_00D0);
    chk("R9 svc written", saved_psr, 32'h6000_00D0);
    psr_wr(1'b0, 4'b0001, 32'h0000_00D2);
    chk("R9 irq own", saved_psr, 32'h0);
    psr_wr(1'b0, 4'b0001, 32'h0000_00D3);
    chk("R9 svc kept", saved_psr, 32'h6000_00D0);

    // R12 write during mode change lands in old view
    wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'h77;
    psr_wr(1'b0, 4'b0001, 32'h0000_00D2);
    rd("R12 irq r13", 4'd13, 32'h1D);
    psr_wr(1'b0, 4'b0001, 32'h0000_00D3);
    rd("R12 svc r13", 4'd13, 32'h77);

    // R10 invalid mode code 10101
    psr_wr(1'b0, 4'b0001, 32'h0000_00D5);
    chk("R10 psr kept", cur_psr, 32'h0000_00D3);
    chk("R10 err pulse", {31'd0, mode_err}, 32'd1);
    rd("R10 r13 kept", 4'd13, 32'h77);
    tick();
    chk("R10 err clears", {31'd0, mode_err}, 32'd0);

    // R1 reset again mid-run
    rst_n = 1'b0; tick(); rst_n = 1'b1;
    chk("R1 psr after reset", cur_psr, 32'h0000_00D3);
    rd("R1 r8 after reset", 4'd8, 32'h0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule